// File: doc/BRIEF.md
# EEPROM Page-Load Sequencer

This block is the device-side write logic of a byte-wide parallel EEPROM. It watches the active-low chip-enable and write-enable strobes. Each write strobe puts one byte into a page-sized staging buffer, with one valid flag per byte. Bytes can arrive at any offset and in any order. The load phase stays open while strobes keep coming. Once the write strobe has been idle for a set number of clock cycles, the phase closes and an internal program cycle starts.

During the program cycle the block pulls the open-drain ready/busy line low. It copies only the flagged bytes into a behavioural storage array. Every other byte in the target page keeps its old value. The target page is taken from the upper address bits of the most recent load. When the cycle ends, the valid flags clear and the line is released. A combinational read port makes the array contents visible for checking.

Top module: `eeprom_page_seq`

## Requirements
- R1: After reset the busy pull-down is off, every valid flag is clear, and every array byte reads 0xFF.
- R2: A byte is loaded once per strobe, when ce_ni and we_ni are both low after synchronisation. The byte offset comes from addr_i[OFF_W-1:0] and the byte from data_i. A we_ni pulse while ce_ni is high loads nothing and opens no load phase.
- R3: Offsets may be loaded in any order and any number from 1 to 2**OFF_W. Programming writes only the loaded offsets. Every other byte in the page is left unchanged.
- R4: If one offset is loaded twice in a load phase, the later data is programmed.
- R5: The target page is addr_i[ADDR_W-1:OFF_W] of the last load before programming.
- R6: Inputs change between clock edges. After the final write strobe ends, busy_pd_o rises exactly at clock edge LOAD_TO+SYNC_STAGES, counted from that release, and not before.
- R7: Loads spaced closer than the timeout keep one load phase open, however long it lasts in total.
- R8: busy_pd_o stays high for exactly PROG_CYC clock cycles per program cycle.
- R9: Write strobes while busy_pd_o is high load nothing and do not open a new load phase.
- R10: The valid flags clear when programming completes, so a later page write programs only its own bytes.
- R11: rd_data_o returns the array byte at rd_addr_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low, asynchronous |
| we_ni | input | 1 | Write enable, active low, asynchronous |
| addr_i | input | ADDR_W | Byte address: page in upper bits, offset in lower OFF_W bits |
| data_i | input | 8 | Byte to load |
| rd_addr_i | input | ADDR_W | Read address into the array |
| rd_data_o | output | 8 | Array byte at rd_addr_i |
| busy_pd_o | output | 1 | Open-drain busy: 1 pulls the ready/busy line low, 0 releases it |

## Verification
The bench runs page writes of every size from one byte to a full page. Offsets come in scattered order, and the leading loads carry a different page number from the last one. A design that latched the page on the first load, or rewrote the whole buffer, would corrupt neighbouring bytes or the wrong page. The bench checks the timeout edge and the busy length to the exact cycle, so an off-by-one timer shows up. It also checks four cases: a repeated offset, a strobe while busy, a strobe with chip-enable high, and a one-byte write after a full page. These catch stale-data ordering, loads accepted while busy, and valid flags that never clear.

// File: rtl/eeprom_page_pkg.sv
package eeprom_page_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  output logic active_o,
  output logic start_o
);
  logic [STAGES-1:0] ce_q, we_q;
  logic              active_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q[0] <= 1'b1;
      we_q[0] <= 1'b1;
    end else begin
      ce_q[0] <= ce_ni;
      we_q[0] <= we_ni;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ce_q[s] <= 1'b1;
        we_q[s] <= 1'b1;
      end else begin
        ce_q[s] <= ce_q[s-1];
        we_q[s] <= we_q[s-1];
      end
    end
  end

  assign active_o = ~ce_q[STAGES-1] & ~we_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_prev_q <= 1'b0;
    else         active_prev_q <= active_o;
  end

  // combined strobe just went active
  assign start_o = active_o & ~active_prev_q;
endmodule

// File: rtl/page_buffer.sv
module page_buffer #(
  parameter int OFF_W = 5,
  localparam int PAGE = 1 << OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] wr_off_i,
  input  logic [7:0]       wr_data_i,
  input  logic             clr_i,
  input  logic [OFF_W-1:0] rd_off_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic [PAGE-1:0]  mask_o
);
  logic [7:0] bytes_q [PAGE];

  for (genvar b = 0; b < PAGE; b++) begin : g_byte
    logic hit;
    assign hit = wr_i && (wr_off_i == OFF_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bytes_q[b] <= 8'h00;
        mask_o[b]  <= 1'b0;
      end else if (clr_i) begin
        mask_o[b]  <= 1'b0;
      end else if (hit) begin
        bytes_q[b] <= wr_data_i;
        mask_o[b]  <= 1'b1;
      end
    end
  end

  assign rd_data_o  = bytes_q[rd_off_i];
  assign rd_valid_o = mask_o[rd_off_i];
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import eeprom_page_pkg::*;
#(
  parameter int OFF_W    = 5,
  parameter int PAGE_W   = 6,
  parameter int LOAD_TO  = 64,
  parameter int PROG_CYC = 256,
  localparam int PAGE    = 1 << OFF_W,
  localparam int CNT_MAX = (LOAD_TO > PROG_CYC) ? LOAD_TO : PROG_CYC,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              busy_o,
  output logic              buf_wr_o,
  output logic              buf_clr_o,
  output logic              commit_o,
  output logic [OFF_W-1:0]  commit_off_o,
  output logic [PAGE_W-1:0] page_o
);
  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PAGE_W-1:0] page_q;

  assign buf_wr_o = start_i && (state_q != ST_PROG);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    buf_clr_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LOAD;
          cnt_d   = '0;
        end
      end
      ST_LOAD: begin
        if (active_i) begin
          cnt_d = '0;
        end else if (cnt_q == CNT_W'(LOAD_TO - 1)) begin
          state_d = ST_PROG;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PROG: begin
        if (cnt_q == CNT_W'(PROG_CYC - 1)) begin
          state_d   = ST_IDLE;
          cnt_d     = '0;
          buf_clr_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      page_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (buf_wr_o) page_q <= page_i;
    end
  end

  // walk the page one offset per cycle at the start of the program cycle
  assign commit_o     = (state_q == ST_PROG) && (cnt_q < CNT_W'(PAGE));
  assign commit_off_o = cnt_q[OFF_W-1:0];
  assign busy_o       = (state_q == ST_PROG);
  assign page_o       = page_q;
endmodule

// File: rtl/mem_array.sv
module mem_array #(
  parameter int ADDR_W = 11,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] cells_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cells_q[i] <= 8'hFF;
    end else if (we_i) begin
      cells_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = cells_q[raddr_i];
endmodule

// File: rtl/eeprom_page_seq.sv
module eeprom_page_seq #(
  parameter int ADDR_W      = 11,
  parameter int OFF_W       = 5,
  parameter int LOAD_TO     = 64,
  parameter int PROG_CYC    = 256,
  parameter int SYNC_STAGES = 2,
  localparam int PAGE_W     = ADDR_W - OFF_W,
  localparam int PAGE       = 1 << OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_pd_o
);
  logic              strobe_active, strobe_start;
  logic              buf_wr, buf_clr, commit, commit_valid;
  logic [OFF_W-1:0]  commit_off;
  logic [PAGE_W-1:0] page_q;
  logic [7:0]        commit_data;
  logic [PAGE-1:0]   valid_mask;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .we_ni    (we_ni),
    .active_o (strobe_active),
    .start_o  (strobe_start)
  );

  seq_ctrl #(
    .OFF_W    (OFF_W),
    .PAGE_W   (PAGE_W),
    .LOAD_TO  (LOAD_TO),
    .PROG_CYC (PROG_CYC)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (strobe_active),
    .start_i      (strobe_start),
    .page_i       (addr_i[ADDR_W-1:OFF_W]),
    .busy_o       (busy_pd_o),
    .buf_wr_o     (buf_wr),
    .buf_clr_o    (buf_clr),
    .commit_o     (commit),
    .commit_off_o (commit_off),
    .page_o       (page_q)
  );

  page_buffer #(.OFF_W(OFF_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (buf_wr),
    .wr_off_i   (addr_i[OFF_W-1:0]),
    .wr_data_i  (data_i),
    .clr_i      (buf_clr),
    .rd_off_i   (commit_off),
    .rd_data_o  (commit_data),
    .rd_valid_o (commit_valid),
    .mask_o     (valid_mask)
  );

  mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (commit && commit_valid),
    .waddr_i ({page_q, commit_off}),
    .wdata_i (commit_data),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/eeprom_page_seq_chk.sv
module eeprom_page_seq_chk #(
  parameter int PAGE     = 32,
  parameter int PAGE_W   = 6,
  parameter int PROG_CYC = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic [PAGE-1:0]   mask_i,
  input logic [PAGE_W-1:0] page_i
);
  logic [31:0] busy_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len_q <= '0;
    else if (busy_i) busy_len_q <= busy_len_q + 1;
    else             busy_len_q <= '0;
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> busy_len_q == 32'(PROG_CYC)); // R8

  AST_MASK_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> mask_i == '0); // R10

  AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(mask_i)); // R9

  AST_PROG_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> mask_i != '0); // R3

  AST_PAGE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(page_i)); // R5
endmodule

bind eeprom_page_seq eeprom_page_seq_chk #(
  .PAGE     (PAGE),
  .PAGE_W   (PAGE_W),
  .PROG_CYC (PROG_CYC)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_i (busy_pd_o),
  .mask_i (valid_mask),
  .page_i (page_q)
);

// File: tb/tb_eeprom_page_seq.sv
module tb_eeprom_page_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int OW = 3;
  localparam int LT = 12;
  localparam int PC = 20;
  localparam int SS = 2;
  localparam int PAGE = 1 << OW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b0;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          busy;

  int   tests = 0;
  int   fails = 0;
  bit   done = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] pend_d [PAGE];
  bit         pend_v [PAGE];
  int         pend_page = 0;

  eeprom_page_seq #(
    .ADDR_W(AW), .OFF_W(OW), .LOAD_TO(LT), .PROG_CYC(PC), .SYNC_STAGES(SS)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n),
    .addr_i(addr), .data_i(data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_pd_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_byte(int a, int d, int gap);
    @(negedge clk);
    addr = AW'(a);
    data = 8'(d);
    we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    if (!ce_n) begin
      pend_v[a % PAGE] = 1'b1;
      pend_d[a % PAGE] = 8'(d);
      pend_page = a / PAGE;
    end
    repeat (gap) @(negedge clk);
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #1;
      check(req, int'(rd_data), int'(model[a]));
    end
  endtask

  // called right after the final load; intrude>=0 issues a strobe while busy
  task automatic finish_prog(int intrude_addr, int intrude_data);
    int n;
    repeat (LT + SS - 1) @(negedge clk);
    check("R6 early", int'(busy), 0);
    @(negedge clk);
    check("R6 timeout", int'(busy), 1);
    if (intrude_addr >= 0) begin
      addr = AW'(intrude_addr);
      data = 8'(intrude_data);
      we_n = 1'b0;
    end
    n = 1;
    for (int k = 1; k < 4 * PC; k++) begin
      @(negedge clk);
      if (k == 3) we_n = 1'b1;
      if (!busy) break;
      n++;
    end
    check("R8 busy length", n, PC);
    for (int o = 0; o < PAGE; o++) begin
      if (pend_v[o]) model[pend_page * PAGE + o] = pend_d[o];
      pend_v[o] = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    for (int o = 0; o < PAGE; o++) begin pend_v[o] = 1'b0; pend_d[o] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", int'(busy), 0);
    sweep("R1 erased");

    // R3 R5: every page, 1..PAGE bytes, scattered offsets, stray page bits first
    for (int p = 0; p < 8; p++) begin
      int n;
      n = p + 1;
      for (int i = 0; i < n; i++) begin
        int off, pg, d, gap;
        off = (p * 3 + i * 5) % PAGE;
        pg  = (i == n - 1) ? p : (p + 3) % 8;
        d   = (p * 37 + i * 11 + 1) % 256;
        gap = (i == n - 1) ? 0 : ((i % 2) ? LT - 3 : 1);
        load_byte(pg * PAGE + off, d, gap);
      end
      finish_prog(-1, 0);
      sweep("R3 R5 R11");
    end

    // R4 repeated offset keeps latest data
    load_byte(2 * PAGE + 5, 8'hAA, 2);
    load_byte(2 * PAGE + 5, 8'h55, 0);
    finish_prog(-1, 0);
    rd_addr = AW'(2 * PAGE + 5);
    #1;
    check("R4 latest", int'(rd_data), 8'h55);
    sweep("R4");

    // R7 long load phase with spaced strobes
    for (int i = 0; i < 20; i++) begin
      load_byte(6 * PAGE + (i % PAGE), (i * 13 + 7) % 256, (i == 19) ? 0 : LT - 3);
      if (i != 19) check("R7 still loading", int'(busy), 0);
    end
    finish_prog(-1, 0);
    sweep("R7");

    // R9 strobe during busy is ignored
    load_byte(1 * PAGE + 0, 8'h3C, 0);
    finish_prog(1 * PAGE + 7, 8'h99);
    repeat (LT + SS + 4) @(negedge clk);
    check("R9 no new phase", int'(busy), 0);
    sweep("R9");

    // R2 chip enable high gates the strobe
    ce_n = 1'b1;
    load_byte(3 * PAGE + 2, 8'h11, 0);
    @(negedge clk);
    ce_n = 1'b0;
    repeat (LT + SS + 4) @(negedge clk);
    check("R2 ce gate", int'(busy), 0);

    // R10 mask cleared: one byte into a page fully written before
    load_byte(6 * PAGE + 3, 8'h01, 0);
    finish_prog(-1, 0);
    sweep("R10 R2");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule